// File: doc/BRIEF.md
# Ramped Stepper Sequencer

This block moves a stepper motor toward a 16-bit target position, one step at a time. The time between steps follows a linear acceleration and deceleration ramp. The interval at rate index r is K1 − K2·r clock cycles, and r runs from 1 up to a software cap of at most 14. Software writes a target, loads a 16-bit phase pattern and issues a step request. The sequencer then accelerates, cruises at the capped rate, and slows back to rate 1 as it approaches the target. The current position and a busy flag are visible throughout the move.

The phase pattern is a software-chosen rotating word. Full stepping or half stepping is set by the bits written, not by logic in the block. The low bits of the word drive up to eight phase pins. The word turns one place per step, in one direction for forward motion and in the other for reverse.

The target may be rewritten while the motor is moving, and the sequencer follows the new value. If the new target lies behind the motor, the motor first slows to rate 1 in its present direction. Only then does it turn around.

Top module: `ramp_stepper_seq`

## Requirements
- R1: After reset, busy is 0, position is 0, the internal pattern word is 0 and so the phase pins are 0.
- R2: A step request while idle starts a move only if the target differs from the position. A request when they are equal leaves busy low. A request while busy has no effect on the running profile.
- R3: Each step interval lasts K1 − K2·r cycles at the current rate index r. If that value is below 1, the interval is 1 cycle. The first interval of a move uses r = 1 and ends with the first step.
- R4: After each step, let d be the distance still to go. If d > r, the rate rises by one when r is below the cap, falls by one when r is above the cap, and otherwise holds. If d ≤ r, the rate falls by one, but never below 1.
- R5: The rate cap is the max-rate input clamped to the range 1 to 14, so 0 acts as 1 and 15 acts as 14.
- R6: A step toward a higher target adds 1 to position and rotates the pattern left, so bit 15 moves into bit 0. A step toward a lower target subtracts 1 and rotates right, so bit 0 moves into bit 15.
- R7: The phase pins show pattern bits [NCH-1:0]. A pattern write is accepted only while idle; a write while busy is ignored.
- R8: A target write takes effect at any time, and a running move ends on the latest target.
- R9: When a new target lies behind the motion, the sequencer keeps stepping the old way while lowering the rate by one per step until r = 1. It then reverses, and the reversing step follows a P(1) interval.
- R10: Busy falls on the clock edge of the step that reaches the target. Position does not change while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_wr | input | 1 | Write strobe for the target position |
| tgt_in | input | 16 | New target position |
| step_req | input | 1 | Start a move toward the target |
| k1 | input | 16 | Base interval constant K1 |
| k2 | input | 16 | Interval decrement per rate index K2 |
| max_rate | input | 4 | Rate index cap (clamped to 1..14) |
| pat_wr | input | 1 | Write strobe for the phase pattern |
| pat_in | input | 16 | New phase pattern word |
| phase | output | 8 | Phase pin levels (pattern low bits) |
| position | output | 16 | Current position |
| busy | output | 1 | A move is in progress |

## Verification
Some rules hold on every cycle, and the checker tests those continuously:
- position moves by at most one per cycle;
- the pattern turns the way the position moved;
- position is frozen while idle;
- a move only begins after a request;
- busy falls only with the position on the target;
- the rate index stays within 1 to 14.

The bench scenarios show what no single-cycle rule captures. A scoreboard predicts every step's position, phase byte and interval for several constant sets, including saturated intervals and clamped caps. Further scenarios cover requests and pattern writes made while busy, a target extended mid-move, and a reversal. For the reversal, the bench checks the overshoot peak and the P(1) interval before the turn.

// File: rtl/stp_pkg.sv
package stp_pkg;

    localparam int RATE_W   = 4;
    localparam int RATE_TOP = 14;
    localparam int PAT_W    = 16;

    typedef logic [RATE_W-1:0] rate_t;
    typedef logic [PAT_W-1:0]  pat_t;

    typedef enum logic {ST_IDLE, ST_RUN} run_st_e;

    typedef struct packed {
        logic fire;
        logic up;
    } step_t;

    function automatic rate_t clamp_rate(input rate_t m);
        if (m == rate_t'(0))
            return rate_t'(1);
        else if (m > rate_t'(RATE_TOP))
            return rate_t'(RATE_TOP);
        else
            return m;
    endfunction

    // far: remaining distance after the step exceeds the present rate
    function automatic rate_t next_rate(input rate_t r, input logic far, input rate_t cap);
        if (far) begin
            if (r < cap)      return r + rate_t'(1);
            else if (r > cap) return r - rate_t'(1);
            else              return r;
        end else begin
            if (r > rate_t'(1)) return r - rate_t'(1);
            else                return rate_t'(1);
        end
    endfunction

    function automatic pat_t rotate_pat(input pat_t p, input logic up);
        if (up) return {p[PAT_W-2:0], p[PAT_W-1]};
        else    return {p[0], p[PAT_W-1:1]};
    endfunction

endpackage

// File: rtl/stp_period.sv
module stp_period
    import stp_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  rate_t             rate,
    input  logic [PER_W-1:0]  k1,
    input  logic [PER_W-1:0]  k2,
    output logic [PER_W-1:0]  period
);
    localparam int PW = PER_W + RATE_W;

    logic [PW-1:0] prod;
    logic [PW-1:0] k1_ext;

    always_comb begin
        prod   = {{RATE_W{1'b0}}, k2} * {{PER_W{1'b0}}, rate};
        k1_ext = {{RATE_W{1'b0}}, k1};
        if (prod < k1_ext)
            period = k1 - prod[PER_W-1:0];
        else
            period = PER_W'(1);
    end
endmodule

// File: rtl/stp_ramp.sv
module stp_ramp
    import stp_pkg::*;
#(
    parameter int POS_W = 16,
    parameter int PER_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_req,
    input  logic [POS_W-1:0]  pos,
    input  logic [POS_W-1:0]  tgt,
    input  rate_t             max_rate,
    input  logic [PER_W-1:0]  period_in,
    output rate_t             rate_sel,
    output rate_t             rate_q,
    output step_t             step,
    output logic              busy
);
    localparam int DW = POS_W + 1;

    run_st_e             st_q;
    logic                up_q;
    logic [PER_W-1:0]    tmr_q;

    logic signed [DW-1:0] diff, ahead, eff_ahead, d1, rate_s;
    logic                 flip, eff_up, expire, fwd, land, far;
    rate_t                cap;

    always_comb begin
        diff      = $signed({1'b0, tgt}) - $signed({1'b0, pos});
        ahead     = up_q ? diff : -diff;
        flip      = ahead[DW-1] && (rate_q == rate_t'(1));
        eff_ahead = flip ? -ahead : ahead;
        eff_up    = up_q ^ flip;
        fwd       = !eff_ahead[DW-1] && (eff_ahead != '0);
        land      = (eff_ahead == DW'(1));
        d1        = eff_ahead - DW'(1);
        rate_s    = $signed({{(DW-RATE_W){1'b0}}, rate_q});
        far       = d1 > rate_s;
        cap       = clamp_rate(max_rate);
        expire    = (st_q == ST_RUN) && (tmr_q <= PER_W'(1));

        step.fire = expire && (fwd || rate_q > rate_t'(1));
        step.up   = eff_up;

        if (st_q == ST_IDLE)
            rate_sel = rate_t'(1);
        else if (fwd)
            rate_sel = next_rate(rate_q, far, cap);
        else
            rate_sel = (rate_q > rate_t'(1)) ? rate_q - rate_t'(1) : rate_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            up_q   <= 1'b1;
            tmr_q  <= '0;
            rate_q <= rate_t'(1);
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (step_req && diff != '0) begin
                        st_q   <= ST_RUN;
                        up_q   <= !diff[DW-1];
                        rate_q <= rate_t'(1);
                        tmr_q  <= period_in;
                    end
                end
                default: begin
                    if (!expire) begin
                        tmr_q <= tmr_q - PER_W'(1);
                    end else if (!step.fire || (fwd && land)) begin
                        st_q   <= ST_IDLE;
                        rate_q <= rate_t'(1);
                    end else begin
                        up_q   <= eff_up;
                        rate_q <= rate_sel;
                        tmr_q  <= period_in;
                    end
                end
            endcase
        end
    end

    assign busy = (st_q == ST_RUN);
endmodule

// File: rtl/stp_track.sv
module stp_track
    import stp_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tgt_wr,
    input  logic [POS_W-1:0]  tgt_in,
    input  step_t             step,
    output logic [POS_W-1:0]  pos_q,
    output logic [POS_W-1:0]  tgt_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            tgt_q <= '0;
        end else begin
            if (tgt_wr)
                tgt_q <= tgt_in;
            if (step.fire)
                pos_q <= step.up ? pos_q + POS_W'(1) : pos_q - POS_W'(1);
        end
    end
endmodule

// File: rtl/stp_pattern.sv
module stp_pattern
    import stp_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pat_wr,
    input  pat_t            pat_in,
    input  logic            busy,
    input  step_t           step,
    output pat_t            pat_q,
    output logic [NCH-1:0]  phase
);
    always_ff @(posedge clk) begin
        if (rst)
            pat_q <= '0;
        else if (step.fire)
            pat_q <= rotate_pat(pat_q, step.up);
        else if (pat_wr && !busy)
            pat_q <= pat_in;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_pin
        assign phase[i] = pat_q[i];
    end
endmodule

// File: rtl/ramp_stepper_seq.sv
module ramp_stepper_seq
    import stp_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int POS_W = 16,
    parameter int PER_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tgt_wr,
    input  logic [POS_W-1:0]  tgt_in,
    input  logic              step_req,
    input  logic [PER_W-1:0]  k1,
    input  logic [PER_W-1:0]  k2,
    input  logic [RATE_W-1:0] max_rate,
    input  logic              pat_wr,
    input  logic [PAT_W-1:0]  pat_in,
    output logic [NCH-1:0]    phase,
    output logic [POS_W-1:0]  position,
    output logic              busy
);
    rate_t             rate_sel, rate_q;
    step_t             step;
    logic [PER_W-1:0]  period;
    logic [POS_W-1:0]  tgt_q;
    pat_t              pat_q;

    stp_period #(.PER_W(PER_W)) u_period (
        .rate(rate_sel), .k1(k1), .k2(k2), .period(period)
    );

    stp_ramp #(.POS_W(POS_W), .PER_W(PER_W)) u_ramp (
        .clk(clk), .rst(rst), .step_req(step_req), .pos(position), .tgt(tgt_q),
        .max_rate(max_rate), .period_in(period), .rate_sel(rate_sel),
        .rate_q(rate_q), .step(step), .busy(busy)
    );

    stp_track #(.POS_W(POS_W)) u_track (
        .clk(clk), .rst(rst), .tgt_wr(tgt_wr), .tgt_in(tgt_in), .step(step),
        .pos_q(position), .tgt_q(tgt_q)
    );

    stp_pattern #(.NCH(NCH)) u_pattern (
        .clk(clk), .rst(rst), .pat_wr(pat_wr), .pat_in(pat_in), .busy(busy),
        .step(step), .pat_q(pat_q), .phase(phase)
    );
endmodule

// File: rtl/stp_chk.sv
module stp_chk
    import stp_pkg::*;
#(
    parameter int POS_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              step_req,
    input logic              busy,
    input logic [POS_W-1:0]  position,
    input logic [POS_W-1:0]  tgt_q,
    input rate_t             rate_q,
    input pat_t              pat_q
);
    p_unit_move_r6: assert property (@(posedge clk) disable iff (rst)
        (position != $past(position)) |->
        ((position == $past(position) + POS_W'(1)) || (position == $past(position) - POS_W'(1))));

    p_rot_left_r6: assert property (@(posedge clk) disable iff (rst)
        (position == $past(position) + POS_W'(1)) |->
        (pat_q == {$past(pat_q[PAT_W-2:0]), $past(pat_q[PAT_W-1])}));

    p_rot_right_r6: assert property (@(posedge clk) disable iff (rst)
        (position == $past(position) - POS_W'(1)) |->
        (pat_q == {$past(pat_q[0]), $past(pat_q[PAT_W-1:1])}));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(position));

    p_stop_on_target_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (position == $past(tgt_q)));

    p_start_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(step_req));

    p_rate_range_r5: assert property (@(posedge clk) disable iff (rst)
        (rate_q != rate_t'(0)) && (rate_q <= rate_t'(RATE_TOP)));
endmodule

bind ramp_stepper_seq stp_chk #(.POS_W(POS_W)) u_chk (
    .clk(clk), .rst(rst), .step_req(step_req), .busy(busy), .position(position),
    .tgt_q(tgt_q), .rate_q(rate_q), .pat_q(pat_q)
);

// File: tb/sim_ramp_stepper_seq.sv
`timescale 1ns/1ps
module sim_ramp_stepper_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tgt_wr = 1'b0;
    logic [15:0] tgt_in = '0;
    logic        step_req = 1'b0;
    logic [15:0] k1 = 16'd20;
    logic [15:0] k2 = 16'd2;
    logic [3:0]  max_rate = 4'd3;
    logic        pat_wr = 1'b0;
    logic [15:0] pat_in = '0;
    logic [7:0]  phase;
    logic [15:0] position;
    logic        busy;

    ramp_stepper_seq u0 (
        .clk(clk), .rst(rst), .tgt_wr(tgt_wr), .tgt_in(tgt_in), .step_req(step_req),
        .k1(k1), .k2(k2), .max_rate(max_rate), .pat_wr(pat_wr), .pat_in(pat_in),
        .phase(phase), .position(position), .busy(busy)
    );

    always #2 clk = ~clk;

    typedef struct {
        int pos;
        int ph;
        int gap;
    } exp_t;

    exp_t        sb_q[$];
    bit          sb_on = 0;
    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    int          last_cyc = 0;
    int          prev_pos = 0;
    int          last_dir = 0;
    int          flip_gap = -1;
    int          peak = 0;
    int          step_cnt = 0;
    logic [15:0] cur_pat = '0;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops one predicted step per observed position change
    always @(negedge clk) begin
        if (!rst && int'(position) != prev_pos) begin
            int gap;
            int dir;
            exp_t e;
            gap = cyc - last_cyc;
            last_cyc = cyc;
            dir = (int'(position) > prev_pos) ? 1 : -1;
            if (last_dir != 0 && dir != last_dir) flip_gap = gap;
            last_dir = dir;
            if (int'(position) > peak) peak = int'(position);
            step_cnt++;
            prev_pos = int'(position);
            if (sb_on) begin
                if (sb_q.size() == 0) begin
                    chk(0, "R3 R4", "unexpected step at position", int'(position), -1);
                end else begin
                    e = sb_q.pop_front();
                    chk(int'(position) == e.pos, "R4 R6", "step position", int'(position), e.pos);
                    chk(int'(phase) == e.ph, "R6 R7", "step phase", int'(phase), e.ph);
                    chk(gap == e.gap, "R3 R4", "step interval", gap, e.gap);
                end
            end
        end
    end

    // Prediction from the requirements
    task automatic predict(input int from, input int to, input int pk1, input int pk2, input int mx);
        int cap, r, p, per, d1;
        bit up;
        cap = (mx < 1) ? 1 : (mx > 14) ? 14 : mx;
        r = 1;
        p = from;
        up = (to > from);
        forever begin
            exp_t e;
            per = pk1 - pk2 * r;
            if (per < 1) per = 1;
            p = up ? p + 1 : p - 1;
            cur_pat = up ? {cur_pat[14:0], cur_pat[15]} : {cur_pat[0], cur_pat[15:1]};
            e.pos = p;
            e.ph = int'(cur_pat[7:0]);
            e.gap = per;
            sb_q.push_back(e);
            d1 = up ? to - p : p - to;
            if (d1 == 0) break;
            if (d1 > r) begin
                if (r < cap) r++;
                else if (r > cap) r--;
            end else if (r > 1) begin
                r--;
            end
        end
    endtask

    task automatic write_target(input int t);
        @(negedge clk);
        tgt_in = 16'(t);
        tgt_wr = 1'b1;
        @(negedge clk);
        tgt_wr = 1'b0;
    endtask

    task automatic start_move(input int t, input int pk1, input int pk2, input int mx);
        k1 = 16'(pk1);
        k2 = 16'(pk2);
        max_rate = 4'(mx);
        last_dir = 0;
        flip_gap = -1;
        peak = int'(position);
        write_target(t);
        step_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        step_req = 1'b0;
        last_cyc = cyc;
    endtask

    task automatic wait_idle(input string req);
        int n;
        n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(!busy, req, "move finished (busy)", int'(busy), 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_steps(input int n);
        int goal;
        goal = step_cnt + n;
        while (step_cnt < goal) @(negedge clk);
    endtask

    task automatic sb_move(input int t, input int pk1, input int pk2, input int mx, input string req);
        predict(int'(position), t, pk1, pk2, mx);
        sb_on = 1;
        start_move(t, pk1, pk2, mx);
        wait_idle(req);
        sb_on = 0;
        chk(sb_q.size() == 0, req, "predicted steps left over", sb_q.size(), 0);
        sb_q.delete();
        chk(int'(position) == t, req, "final position", int'(position), t);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(position == 16'd0, "R1", "position after reset", int'(position), 0);
        chk(phase == 8'd0, "R1", "phase after reset", int'(phase), 0);

        // R7 pattern load while idle
        @(negedge clk);
        pat_in = 16'hC0F1;
        pat_wr = 1'b1;
        @(negedge clk);
        pat_wr = 1'b0;
        cur_pat = 16'hC0F1;
        chk(phase == 8'hF1, "R7", "phase after idle pattern write", int'(phase), 'hF1);

        // R2 request with target equal to position
        write_target(0);
        step_req = 1'b1;
        @(negedge clk);
        step_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R2", "busy with target reached", int'(busy), 0);
        chk(position == 16'd0, "R2", "position with target reached", int'(position), 0);

        // R3 R4 R6 R10 forward ramp
        sb_move(6, 20, 2, 3, "R10");
        repeat (20) @(negedge clk);
        chk(position == 16'd6, "R10", "position held while idle", int'(position), 6);

        // R6 reverse ramp
        sb_move(2, 20, 2, 3, "R6");

        // R3 R5 saturated intervals with cap 15 -> 14
        sb_move(42, 10, 1, 15, "R5");
        // R5 cap 0 -> 1
        sb_move(45, 20, 2, 0, "R5");

        // R2 R7 request and pattern write while busy are ignored
        predict(int'(position), 52, 20, 2, 3);
        sb_on = 1;
        start_move(52, 20, 2, 3);
        wait_steps(2);
        step_req = 1'b1;
        pat_in = 16'hFFFF;
        pat_wr = 1'b1;
        @(negedge clk);
        step_req = 1'b0;
        pat_wr = 1'b0;
        wait_idle("R2");
        sb_on = 0;
        chk(sb_q.size() == 0, "R2", "predicted steps left over", sb_q.size(), 0);
        sb_q.delete();
        chk(int'(phase) == int'(cur_pat[7:0]), "R7", "phase after busy write", int'(phase), int'(cur_pat[7:0]));

        // R8 target extended mid-move
        start_move(56, 20, 2, 3);
        wait_steps(1);
        write_target(60);
        wait_idle("R8");
        chk(position == 16'd60, "R8", "final position after extension", int'(position), 60);

        // R9 reversal: decelerate in old direction, then turn at rate 1
        start_move(80, 20, 2, 3);
        wait_steps(3);
        write_target(58);
        wait_idle("R9");
        chk(peak == 65, "R9", "overshoot peak", peak, 65);
        chk(flip_gap == 18, "R9", "interval before reversing step", flip_gap, 18);
        chk(position == 16'd58, "R9", "final position after reversal", int'(position), 58);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule